// File: doc/BRIEF.md
# Link Board Host Control Flags

This block joins a host processor to a communication coprocessor subsystem. Both sides see a shared byte memory through their own ports, and each side also has a small set of flag registers. The host owns an enable flag and a handshake flag. The coprocessor owns a sync register and a handshake register of its own. The two handshake flags are cross-read: the coprocessor sees the host flag inverted in the top bit of its handshake readback.

The host enable flag holds the entire coprocessor subsystem in reset (the processor, its DMA engine and its link controller) until software sets it. The block also issues the coprocessor's interrupt request and presents a vector beside it. A vertical-sync tick can raise a request that stays pending until the coprocessor acknowledges it. The link controller's interrupt line gives a level-following request that takes precedence over the pending one.

Each port is a simple byte bus. Address bit `MEM_AW` low selects the shared memory. With that bit high, address bit 0 selects one of the two flag registers on that side. Read data is registered and valid on the cycle after the read strobe.

Top module: `link_host_flags`

## Requirements
- R1: After reset, `sub_rst_n` and `c_irq` are low. The host enable register (address bit 12 high, bit 0 low) reads 0xFE. The host flag register (address bit 12 high, bit 0 high) reads 0xFE. The coprocessor sync register (bit 12 high, bit 0 low) reads 0xFC. The coprocessor handshake register (bit 12 high, bit 0 high) reads 0xFE.
- R2: With address bit 12 low, either port reads and writes the 4096-byte shared memory. A byte written from one port can be read from the other port. Read data appears one cycle after the read strobe.
- R3: If both ports write the same memory address in the same cycle, the host byte is stored. If they write different addresses in the same cycle, both bytes are stored.
- R4: The host enable register stores data bit 0 and reads back as 0xFE with that bit in bit 0. `sub_rst_n` equals the stored bit from the cycle after the write.
- R5: The host flag register stores data bit 0 and reads back as 0xFE with that bit in bit 0.
- R6: The sync register keeps data bits 1:0 and reads back as the stored bits ORed with 0xFC.
- R7: The coprocessor handshake register keeps data bit 0. Its readback holds that bit in bit 0, ones in bits 6:1, and the inverse of the host flag in bit 7.
- R8: While enabled and sync bit 1 is set, a `vsync_tick` raises `c_irq` from the next cycle with vector 0xEF. The request stays up until `c_iack`. A tick has no effect while sync bit 1 is clear.
- R9: A high `link_irq` drives `c_irq` high in the same cycle with vector 0xFF. This vector takes precedence over a pending sync request, and the request drops when the line drops.
- R10: While the enable bit is low, `c_irq` stays low, a pending sync request is cleared, and ticks are ignored.
- R11: `c_iack` clears a pending sync request only while `link_irq` is low. An acknowledge given while the link vector is showing leaves the sync request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cs | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 13 | Host address; bit 12 selects the registers |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, one cycle after strobe |
| c_cs | input | 1 | Coprocessor access strobe |
| c_we | input | 1 | Coprocessor write (1) or read (0) |
| c_addr | input | 13 | Coprocessor address; bit 12 selects the registers |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data, one cycle after strobe |
| vsync_tick | input | 1 | One-cycle vertical-sync pulse |
| link_irq | input | 1 | Link controller interrupt level |
| c_iack | input | 1 | Coprocessor interrupt acknowledge |
| sub_rst_n | output | 1 | Active-low reset to the coprocessor subsystem |
| c_irq | output | 1 | Coprocessor interrupt request |
| c_vector | output | 8 | Interrupt vector |

## Verification
A corrupted enable flag shows at once on `sub_rst_n`, on the cycle after the host write. A lost or stuck sync request shows on `c_irq` the cycle after a tick or an acknowledge. Flag and sync register faults appear in the next read of either side's readback word, including the inverted cross-read bit. A wrong collision rule in the shared memory stays hidden until that address is read back, so the bench reads back every address it collides on.

// File: rtl/link_host_flags.sv
module link_host_flags #(
  parameter int          MEM_AW    = 12,
  parameter logic [7:0]  VEC_VSYNC = 8'hEF,
  parameter logic [7:0]  VEC_LINK  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_cs,
  input  logic              h_we,
  input  logic [MEM_AW:0]   h_addr,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  input  logic              c_cs,
  input  logic              c_we,
  input  logic [MEM_AW:0]   c_addr,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata,
  input  logic              vsync_tick,
  input  logic              link_irq,
  input  logic              c_iack,
  output logic              sub_rst_n,
  output logic              c_irq,
  output logic [7:0]        c_vector
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];

  logic       en, fg, zfg, vs_pend;
  logic [1:0] syn;

  wire [MEM_AW-1:0] h_ma = h_addr[MEM_AW-1:0];
  wire [MEM_AW-1:0] c_ma = c_addr[MEM_AW-1:0];

  wire h_mem = h_cs & ~h_addr[MEM_AW];
  wire h_reg = h_cs &  h_addr[MEM_AW];
  wire c_mem = c_cs & ~c_addr[MEM_AW];
  wire c_reg = c_cs &  c_addr[MEM_AW];

  wire h_mwr = h_mem & h_we;
  wire c_mwr = c_mem & c_we;
  wire clash = h_mwr & c_mwr & (h_ma == c_ma);

  wire [7:0] h_regval = h_addr[0] ? {7'h7F, fg} : {7'h7F, en};
  wire [7:0] c_regval = c_addr[0] ? {~fg, 6'h3F, zfg} : {6'h3F, syn};

  always_ff @(posedge clk) begin
    if (h_mwr) mem[h_ma] <= h_wdata;
    if (c_mwr && !clash) mem[c_ma] <= c_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= 8'h00;
      c_rdata <= 8'h00;
    end else begin
      if (h_cs && !h_we) h_rdata <= h_mem ? mem[h_ma] : h_regval;
      if (c_cs && !c_we) c_rdata <= c_mem ? mem[c_ma] : c_regval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      fg  <= 1'b0;
      syn <= 2'b00;
      zfg <= 1'b0;
    end else begin
      if (h_reg && h_we) begin
        if (h_addr[0]) fg <= h_wdata[0];
        else           en <= h_wdata[0];
      end
      if (c_reg && c_we) begin
        if (c_addr[0]) zfg <= c_wdata[0];
        else           syn <= c_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)                vs_pend <= 1'b0;
    else if (vsync_tick && syn[1])    vs_pend <= 1'b1;
    else if (c_iack && !link_irq)     vs_pend <= 1'b0;
  end

  assign sub_rst_n = en;
  assign c_irq     = en & (link_irq | vs_pend);
  assign c_vector  = link_irq ? VEC_LINK : VEC_VSYNC;

endmodule

module link_host_flags_chk #(
  parameter int         MEM_AW   = 12,
  parameter logic [7:0] VEC_LINK = 8'hFF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            h_cs,
  input logic            h_we,
  input logic [MEM_AW:0] h_addr,
  input logic [7:0]      h_wdata,
  input logic            c_cs,
  input logic            c_we,
  input logic [MEM_AW:0] c_addr,
  input logic [7:0]      c_rdata,
  input logic            vsync_tick,
  input logic            link_irq,
  input logic            c_iack,
  input logic            sub_rst_n,
  input logic            c_irq,
  input logic [7:0]      c_vector,
  input logic            syn_hi,
  input logic            vs_pend
);

  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cs && h_we && h_addr[MEM_AW] && !h_addr[0]) |=> (sub_rst_n == $past(h_wdata[0]))); // R4

  AST_NO_IRQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_rst_n |-> !c_irq); // R10

  AST_PEND_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_rst_n |=> !vs_pend); // R10

  AST_LINK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rst_n && link_irq) |-> (c_irq && c_vector == VEC_LINK)); // R9

  AST_VSYNC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rst_n && syn_hi && vsync_tick) |=> (c_irq || !sub_rst_n)); // R8

  AST_VSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_irq && !link_irq && !c_iack) |=> (c_irq || !sub_rst_n)); // R8

  AST_ACK_UNDER_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_pend && sub_rst_n && link_irq) |=> (vs_pend || !sub_rst_n)); // R11

  AST_SYNC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cs && !c_we && c_addr[MEM_AW] && !c_addr[0]) |=> (c_rdata[7:2] == 6'h3F)); // R6

  AST_HS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cs && !c_we && c_addr[MEM_AW] && c_addr[0]) |=> (c_rdata[6:1] == 6'h3F)); // R7

endmodule

bind link_host_flags link_host_flags_chk #(.MEM_AW(MEM_AW), .VEC_LINK(VEC_LINK)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_cs(h_cs), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .c_cs(c_cs), .c_we(c_we), .c_addr(c_addr), .c_rdata(c_rdata),
  .vsync_tick(vsync_tick), .link_irq(link_irq), .c_iack(c_iack),
  .sub_rst_n(sub_rst_n), .c_irq(c_irq), .c_vector(c_vector),
  .syn_hi(syn[1]), .vs_pend(vs_pend)
);

// File: tb/link_host_flags_tb.sv
module link_host_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] REG_A = 13'h1000;
  localparam logic [12:0] REG_B = 13'h1001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_cs = 0, h_we = 0, c_cs = 0, c_we = 0;
  logic [12:0] h_addr = '0, c_addr = '0;
  logic [7:0]  h_wdata = '0, c_wdata = '0;
  logic [7:0]  h_rdata, c_rdata, c_vector;
  logic        vsync_tick = 0, link_irq = 0, c_iack = 0;
  logic        sub_rst_n, c_irq;

  int vec_cnt = 0;
  int err_cnt = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_host_flags u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_cs(h_cs), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_cs(c_cs), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .vsync_tick(vsync_tick), .link_irq(link_irq), .c_iack(c_iack),
    .sub_rst_n(sub_rst_n), .c_irq(c_irq), .c_vector(c_vector)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic h_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); h_cs = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_cs = 0; h_we = 0;
  endtask

  task automatic c_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); c_cs = 1; c_we = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_cs = 0; c_we = 0;
  endtask

  task automatic h_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); h_cs = 1; h_we = 0; h_addr = a;
    @(negedge clk); h_cs = 0; d = h_rdata;
  endtask

  task automatic c_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); c_cs = 1; c_we = 0; c_addr = a;
    @(negedge clk); c_cs = 0; d = c_rdata;
  endtask

  task automatic tick;
    @(negedge clk); vsync_tick = 1;
    @(negedge clk); vsync_tick = 0;
  endtask

  task automatic ack;
    @(negedge clk); c_iack = 1;
    @(negedge clk); c_iack = 0;
  endtask

  task automatic t_reset;
    chk("R1 sub_rst_n", {7'b0, sub_rst_n}, 8'h00);
    chk("R1 c_irq", {7'b0, c_irq}, 8'h00);
    h_rd(REG_A, rd); chk("R1 host enable", rd, 8'hFE);
    h_rd(REG_B, rd); chk("R1 host flag", rd, 8'hFE);
    c_rd(REG_A, rd); chk("R1 sync", rd, 8'hFC);
    c_rd(REG_B, rd); chk("R1 handshake", rd, 8'hFE);
  endtask

  task automatic t_mem;
    h_wr(13'h0005, 8'hA5);
    c_rd(13'h0005, rd); chk("R2 host->cop", rd, 8'hA5);
    c_wr(13'h0FFF, 8'h3C);
    h_rd(13'h0FFF, rd); chk("R2 cop->host top", rd, 8'h3C);
    h_rd(13'h0005, rd); chk("R2 host own", rd, 8'hA5);
  endtask

  task automatic t_clash;
    @(negedge clk);
    h_cs = 1; h_we = 1; h_addr = 13'h0123; h_wdata = 8'h11;
    c_cs = 1; c_we = 1; c_addr = 13'h0123; c_wdata = 8'h22;
    @(negedge clk);
    h_addr = 13'h0200; h_wdata = 8'h33;
    c_addr = 13'h0201; c_wdata = 8'h44;
    @(negedge clk); h_cs = 0; h_we = 0; c_cs = 0; c_we = 0;
    h_rd(13'h0123, rd); chk("R3 same addr host wins", rd, 8'h11);
    c_rd(13'h0123, rd); chk("R3 same addr cop view", rd, 8'h11);
    c_rd(13'h0200, rd); chk("R3 diff addr host", rd, 8'h33);
    h_rd(13'h0201, rd); chk("R3 diff addr cop", rd, 8'h44);
  endtask

  task automatic t_enable;
    h_wr(REG_A, 8'h01);
    chk("R4 release", {7'b0, sub_rst_n}, 8'h01);
    h_rd(REG_A, rd); chk("R4 readback set", rd, 8'hFF);
    h_wr(REG_A, 8'hFE);
    chk("R4 hold", {7'b0, sub_rst_n}, 8'h00);
    h_rd(REG_A, rd); chk("R4 readback clear", rd, 8'hFE);
  endtask

  task automatic t_flags;
    h_wr(REG_B, 8'h01);
    h_rd(REG_B, rd); chk("R5 flag set", rd, 8'hFF);
    c_rd(REG_B, rd); chk("R7 cross inverted", rd, 8'h7E);
    c_wr(REG_B, 8'hFF);
    c_rd(REG_B, rd); chk("R7 own bit", rd, 8'h7F);
    h_wr(REG_B, 8'hFE);
    h_rd(REG_B, rd); chk("R5 flag clear", rd, 8'hFE);
    c_rd(REG_B, rd); chk("R7 cross clear", rd, 8'hFF);
    c_wr(REG_B, 8'h00);
  endtask

  task automatic t_sync;
    c_wr(REG_A, 8'hFF);
    c_rd(REG_A, rd); chk("R6 sync ff", rd, 8'hFF);
    c_wr(REG_A, 8'h01);
    c_rd(REG_A, rd); chk("R6 sync 01", rd, 8'hFD);
  endtask

  task automatic t_vsync;
    h_wr(REG_A, 8'h01);
    c_wr(REG_A, 8'h00);
    tick;
    chk("R8 tick ignored sync clear", {7'b0, c_irq}, 8'h00);
    c_wr(REG_A, 8'h02);
    tick;
    chk("R8 raise", {7'b0, c_irq}, 8'h01);
    chk("R8 vector", c_vector, 8'hEF);
    repeat (3) @(negedge clk);
    chk("R8 held", {7'b0, c_irq}, 8'h01);
    ack;
    chk("R8 ack clears", {7'b0, c_irq}, 8'h00);
  endtask

  task automatic t_link;
    @(negedge clk); link_irq = 1; #1;
    chk("R9 level irq", {7'b0, c_irq}, 8'h01);
    chk("R9 vector", c_vector, 8'hFF);
    @(negedge clk); link_irq = 0; #1;
    chk("R9 follows drop", {7'b0, c_irq}, 8'h00);
    tick;
    @(negedge clk); link_irq = 1; #1;
    chk("R9 precedence", c_vector, 8'hFF);
    ack;
    @(negedge clk); link_irq = 0; #1;
    chk("R11 ack under link ignored", {7'b0, c_irq}, 8'h01);
    chk("R11 vsync vector back", c_vector, 8'hEF);
    ack;
    chk("R11 ack clears", {7'b0, c_irq}, 8'h00);
  endtask

  task automatic t_hold;
    tick;
    chk("R10 pending before hold", {7'b0, c_irq}, 8'h01);
    h_wr(REG_A, 8'h00);
    chk("R10 irq off in hold", {7'b0, c_irq}, 8'h00);
    tick;
    @(negedge clk); link_irq = 1; #1;
    chk("R10 link masked", {7'b0, c_irq}, 8'h00);
    @(negedge clk); link_irq = 0;
    h_wr(REG_A, 8'h01);
    chk("R10 pending flushed", {7'b0, c_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mem;
    t_clash;
    t_enable;
    t_flags;
    t_sync;
    t_vsync;
    t_link;
    t_hold;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule